// File: doc/BRIEF.md
# Daisy-Chain Pulse-Position Transmitter

This block is the host side of a single-wire daisy chain of LED driver receivers. One start request sends a whole frame. The host samples a bit period (in system clocks) and a device count when it starts. For each device it then asks its client for one 36-bit channel payload, using a request/valid handshake. It prepends the fixed 12-bit write header `001110101010` (hex 3AA) and shifts the 48-bit packet out most significant bit first. Every packet is followed by a short low hold that closes that device's communication cycle. After the last packet, a longer low hold tells every receiver to latch its data at the same moment.

Each bit occupies one slot of `P` system clocks. Every slot opens with a rising edge and a short high pulse. A one carries a second rising edge a quarter of the way into the slot; a zero has no second edge. The header begins with two zeros, so the first two slot openings of each packet give the receiver the spacing from which it learns `P`. All packets of a frame use the same period. A changed payload for any device means a whole new frame.

Top module: `chain_tx`

## Requirements
- R1: `pkt_req` rises once per packet. The payload is taken at the clock edge where `pkt_req` and `pkt_valid` are both high. A frame makes exactly `dev_count` requests and transmits exactly that many packets.
- R2: Each packet is 48 bits, most significant first: the header 12'h3AA (bits 47..36), then payload bits 35..0.
- R3: Within a packet, slots open every `P` cycles with a rising edge, and every high pulse on `sdo` lasts `P>>3` cycles.
- R4: A one bit has a second rising edge exactly `P>>2` cycles after its slot opens. No other rising edge occurs inside a slot.
- R5: After each packet, `sdo` stays low for 5 slot periods. When the next payload is already valid, the next packet's first rising edge comes exactly `6P+1` cycles after the previous packet's last slot opened.
- R6: After the last packet's hold, `sdo` stays low for 12 more slot periods. `busy` falls exactly `18P` cycles after the last slot of the frame opened.
- R7: Out of reset, `sdo`, `busy` and `pkt_req` are low. `busy` is high two clock edges after the edge that accepts a start and stays high until the frame ends.
- R8: `period_in` and `dev_count` are captured when a start is accepted. A start pulse, or new `period_in` or `dev_count` values, during a frame changes neither the frame nor what follows it.
- R9: A `period_in` below 16 is raised to 16 system clocks.
- R10: A start with `dev_count` equal to 0 is ignored: `busy`, `pkt_req` and `sdo` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request, honoured when idle |
| period_in | input | PERIOD_W | Bit slot length in system clocks |
| dev_count | input | COUNT_W | Number of receivers in the chain |
| pkt_req | output | 1 | Asks for the next 36-bit payload |
| pkt_valid | input | 1 | Payload on `pkt_data` is valid |
| pkt_data | input | PAY_W | Channel payload for the current device |
| sdo | output | 1 | Serial line to the first receiver |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check these on every cycle: the line stays low through both holds, rising edges appear only at a slot's opening or its quarter point, one request is raised per payload taken, the header is loaded with every payload, `busy` follows the sequencer, and the captured period does not change during a frame. Other properties span a whole frame and only the bench scenarios can show them. These are the decoded bit values, exact slot spacing and pulse widths, the exact gaps between packets, the end-of-frame timing of `busy`, the clamping of short periods, and the fact that a start or new settings arriving mid-frame leave that frame's packet count and timing unchanged.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_EOS,
    ST_LATCH
  } tx_state_e;

  // Period actually used: never below the floor.
  function automatic int unsigned clamp_period(input int unsigned p, input int unsigned pmin);
    return (p < pmin) ? pmin : p;
  endfunction

  // Line level at offset t of a slot of length p carrying bit b.
  function automatic logic pulse_level(input logic b, input int unsigned t, input int unsigned p);
    int unsigned hi;
    int unsigned q;
    hi = p >> 3;
    q  = p >> 2;
    return (t < hi) || (b && (t >= q) && (t < q + hi));
  endfunction

endpackage

// File: rtl/chain_tx_slot_timer.sv
module chain_tx_slot_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic [PW-1:0] slot_pos,
  output logic          slot_last
);

  assign slot_last = run && (slot_pos == period - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             slot_pos <= '0;
    else if (!run || slot_last) slot_pos <= '0;
    else                    slot_pos <= slot_pos + PW'(1);
  end

  a_r3_pos_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (slot_pos < period));

endmodule

// File: rtl/chain_tx_seq.sv
module chain_tx_seq
  import chain_tx_pkg::*;
#(
  parameter int          PW          = 16,
  parameter int          CW          = 8,
  parameter int          PAY_W       = 36,
  parameter int          CMD_W       = 12,
  parameter logic [11:0] CMD         = 12'h3AA,
  parameter int          EOS_SLOTS   = 5,
  parameter int          LATCH_SLOTS = 12,
  parameter int          MIN_PERIOD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PW-1:0]    period_in,
  input  logic [CW-1:0]    dev_count,
  input  logic             pkt_valid,
  input  logic [PAY_W-1:0] pkt_data,
  input  logic             slot_last,
  output tx_state_e        state,
  output logic             pkt_req,
  output logic             pkt_take,
  output logic             run,
  output logic             cur_bit,
  output logic [PW-1:0]    period_q
);

  localparam int PKT_W    = CMD_W + PAY_W;
  localparam int BW       = $clog2(PKT_W);
  localparam int GAP_MAX  = (EOS_SLOTS > LATCH_SLOTS) ? EOS_SLOTS : LATCH_SLOTS;
  localparam int GW       = $clog2(GAP_MAX + 1);

  logic [PKT_W-1:0] shreg;
  logic [BW-1:0]    bit_idx;
  logic [GW-1:0]    gap_idx;
  logic [CW-1:0]    left;
  logic             start_ok;
  logic             last_bit;
  logic             eos_end;
  logic             latch_end;

  assign start_ok  = (state == ST_IDLE) && start && (dev_count != '0);
  assign pkt_req   = (state == ST_REQ);
  assign pkt_take  = pkt_req && pkt_valid;
  assign run       = (state == ST_DATA) || (state == ST_EOS) || (state == ST_LATCH);
  assign cur_bit   = shreg[PKT_W-1];
  assign last_bit  = (state == ST_DATA) && slot_last && (bit_idx == BW'(PKT_W - 1));
  assign eos_end   = (state == ST_EOS) && slot_last && (gap_idx == GW'(EOS_SLOTS - 1));
  assign latch_end = (state == ST_LATCH) && slot_last && (gap_idx == GW'(LATCH_SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      gap_idx  <= '0;
      left     <= '0;
      period_q <= PW'(MIN_PERIOD);
    end else begin
      unique case (state)
        ST_IDLE: if (start_ok) begin
          period_q <= PW'(clamp_period(32'(period_in), MIN_PERIOD));
          left     <= dev_count;
          state    <= ST_REQ;
        end
        ST_REQ: if (pkt_take) begin
          shreg   <= {CMD, pkt_data};
          bit_idx <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: if (last_bit) begin
          gap_idx <= '0;
          state   <= ST_EOS;
        end else if (slot_last) begin
          shreg   <= {shreg[PKT_W-2:0], 1'b0};
          bit_idx <= bit_idx + BW'(1);
        end
        ST_EOS: if (eos_end) begin
          gap_idx <= '0;
          if (left == CW'(1)) state <= ST_LATCH;
          else begin
            left  <= left - CW'(1);
            state <= ST_REQ;
          end
        end else if (slot_last) gap_idx <= gap_idx + GW'(1);
        ST_LATCH: if (latch_end) state <= ST_IDLE;
          else if (slot_last) gap_idx <= gap_idx + GW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_take |=> !pkt_req);

  a_r2_header_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_take |=> (shreg[PKT_W-1 -: CMD_W] == CMD));

  a_r8_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state == ST_IDLE || $stable(period_q)));

  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && dev_count == '0) |=> (state == ST_IDLE));

endmodule

// File: rtl/chain_tx_line_enc.sv
module chain_tx_line_enc
  import chain_tx_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tx_state_e     state,
  input  logic [PW-1:0] slot_pos,
  input  logic          cur_bit,
  input  logic [PW-1:0] period_q,
  output logic          sdo,
  output logic          busy
);

  logic level;

  assign level = (state == ST_DATA) && pulse_level(cur_bit, 32'(slot_pos), 32'(period_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo  <= 1'b0;
      busy <= 1'b0;
    end else begin
      sdo  <= level;
      busy <= (state != ST_IDLE);
    end
  end

  a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EOS || state == ST_LATCH) |=> !sdo);

  a_r4_edge_spot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo) |-> ($past(slot_pos) == '0 || $past(slot_pos) == (period_q >> 2)));

  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> busy);

endmodule

// File: rtl/chain_tx.sv
module chain_tx
  import chain_tx_pkg::*;
#(
  parameter int          PERIOD_W    = 16,
  parameter int          COUNT_W     = 8,
  parameter int          PAY_W       = 36,
  parameter int          CMD_W       = 12,
  parameter logic [11:0] CMD         = 12'h3AA,
  parameter int          EOS_SLOTS   = 5,
  parameter int          LATCH_SLOTS = 12,
  parameter int          MIN_PERIOD  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PERIOD_W-1:0] period_in,
  input  logic [COUNT_W-1:0]  dev_count,
  output logic                pkt_req,
  input  logic                pkt_valid,
  input  logic [PAY_W-1:0]    pkt_data,
  output logic                sdo,
  output logic                busy
);

  tx_state_e           state;
  logic                pkt_take;
  logic                run;
  logic                cur_bit;
  logic                slot_last;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] slot_pos;

  chain_tx_slot_timer #(.PW(PERIOD_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .period    (period_q),
    .slot_pos  (slot_pos),
    .slot_last (slot_last)
  );

  chain_tx_seq #(
    .PW          (PERIOD_W),
    .CW          (COUNT_W),
    .PAY_W       (PAY_W),
    .CMD_W       (CMD_W),
    .CMD         (CMD),
    .EOS_SLOTS   (EOS_SLOTS),
    .LATCH_SLOTS (LATCH_SLOTS),
    .MIN_PERIOD  (MIN_PERIOD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .period_in (period_in),
    .dev_count (dev_count),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .slot_last (slot_last),
    .state     (state),
    .pkt_req   (pkt_req),
    .pkt_take  (pkt_take),
    .run       (run),
    .cur_bit   (cur_bit),
    .period_q  (period_q)
  );

  chain_tx_line_enc #(.PW(PERIOD_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .slot_pos (slot_pos),
    .cur_bit  (cur_bit),
    .period_q (period_q),
    .sdo      (sdo),
    .busy     (busy)
  );

  a_r1_take_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_take |-> busy || $past(state) == ST_IDLE);

endmodule

// File: tb/sim_chain_tx.sv
module sim_chain_tx;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] period_in = 16'd24;
  logic [7:0]  dev_count = 8'd0;
  logic        pkt_req;
  logic        pkt_valid = 1'b0;
  logic [35:0] pkt_data = '0;
  logic        sdo;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;

  logic [47:0] exp_q[$];
  int unsigned p_exp = 24;
  bit          exact = 1'b0;
  int          frames_done = 0;
  int          pkts_done = 0;

  chain_tx u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_in(period_in),
    .dev_count(dev_count), .pkt_req(pkt_req), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .sdo(sdo), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: decodes the line and scores against the queue
  logic        prev_sdo = 1'b0, prev_busy = 1'b0, in_pkt = 1'b0, have_prev = 1'b0, cur_bit = 1'b0;
  int unsigned slot_start = 0, last_slot = 0, pulse_start = 0, bit_cnt = 0;
  logic [47:0] word = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sdo = 0; prev_busy = 0; in_pkt = 0; have_prev = 0;
    end else begin
      logic rise, fall, used;
      logic [47:0] expw;
      rise = sdo && !prev_sdo;
      fall = !sdo && prev_sdo;
      used = 1'b0;
      if (in_pkt && (cyc - slot_start == p_exp)) begin
        word = {word[46:0], cur_bit};
        bit_cnt++;
        if (bit_cnt == 48) begin
          in_pkt = 0; last_slot = slot_start; have_prev = 1; pkts_done++;
          if (exp_q.size() == 0) check(0, "R1", "unrequested packet", word, 0);
          else begin
            expw = exp_q.pop_front();
            check(word == expw, "R2", "packet content", word, expw);
          end
        end else begin
          check(rise, "R3", "slot opening edge", 64'(sdo), 1);
          slot_start = cyc; cur_bit = 0; used = 1'b1;
        end
      end
      if (rise && !used) begin
        if (in_pkt) begin
          check(cyc - slot_start == (p_exp >> 2), "R4", "second edge offset",
                cyc - slot_start, p_exp >> 2);
          cur_bit = 1;
        end else begin
          if (have_prev) begin
            if (exact) check(cyc - last_slot == 6*p_exp + 1, "R5", "packet gap",
                             cyc - last_slot, 6*p_exp + 1);
            else check(cyc - last_slot >= 6*p_exp + 1, "R5", "packet gap minimum",
                       cyc - last_slot, 6*p_exp + 1);
          end
          in_pkt = 1; slot_start = cyc; bit_cnt = 0; cur_bit = 0; word = '0;
        end
      end
      if (rise) pulse_start = cyc;
      if (fall) check(cyc - pulse_start == (p_exp >> 3), "R3", "pulse width",
                      cyc - pulse_start, p_exp >> 3);
      if (prev_busy && !busy) begin
        check(have_prev && (cyc - last_slot == 18*p_exp), "R6", "busy fall after latch hold",
              cyc - last_slot, 18*p_exp);
        check(exp_q.size() == 0, "R1", "payloads left untransmitted", exp_q.size(), 0);
        have_prev = 0;
        frames_done++;
      end
      prev_sdo = sdo;
      prev_busy = busy;
    end
  end

  // Driver: runs one frame and pushes the expected packets
  task automatic run_frame(input int per, input int cnt, input int pexp, input int stall,
                           input bit poke, input logic [35:0] d0, input logic [35:0] d1,
                           input logic [35:0] d2);
    int f0, pk0;
    logic [35:0] d;
    @(negedge clk);
    p_exp = pexp; exact = (stall == 0);
    period_in = 16'(per); dev_count = 8'(cnt); start = 1'b1;
    f0 = frames_done; pk0 = pkts_done;
    @(negedge clk);
    start = 1'b0;
    check(pkt_req == 1'b1, "R1", "request after start", 64'(pkt_req), 1);
    @(negedge clk);
    check(busy == 1'b1, "R7", "busy after start", 64'(busy), 1);
    for (int i = 0; i < cnt; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      if (poke && i == 1) begin
        start = 1'b1; period_in = 16'd50; dev_count = 8'd9;
        @(negedge clk);
        start = 1'b0;
      end
      repeat (stall) @(negedge clk);
      pkt_data = d; pkt_valid = 1'b1;
      while (!pkt_req) @(negedge clk);
      exp_q.push_back({12'b001110101010, d});
      @(negedge clk);
      if (stall != 0) pkt_valid = 1'b0;
    end
    pkt_valid = 1'b0;
    while (frames_done == f0) @(negedge clk);
    check(pkts_done - pk0 == cnt, "R1", "packets in frame", pkts_done - pk0, cnt);
    repeat (6) @(negedge clk);
    check(!busy && !pkt_req && !sdo, "R8", "no restart after frame",
          {busy, pkt_req, sdo}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sdo && !busy && !pkt_req, "R7", "reset state", {sdo, busy, pkt_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sdo && !busy && !pkt_req, "R7", "idle after reset", {sdo, busy, pkt_req}, 0);

    // R10: zero device count
    dev_count = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      check(!busy && !pkt_req && !sdo, "R10", "zero count start", {busy, pkt_req, sdo}, 0);
      @(negedge clk);
    end

    // R2 R3 R4 R5 R6: three devices, payload always ready
    run_frame(24, 3, 24, 0, 0, 36'hFFFFFFFFF, 36'h5A3C96E01, 36'h000000000);
    // R8: stalled payloads, start and new settings mid-frame
    run_frame(37, 2, 37, 9, 1, 36'h123456789, 36'h800000001, 36'h0);
    // R9: short period clamped
    run_frame(5, 1, 16, 0, 0, 36'hF0F0F0F0F, 36'h0, 36'h0);
    run_frame(20, 2, 20, 0, 0, 36'h000000FFF, 36'hFFF000000, 36'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule